// File: doc/BRIEF.md
# Transmit Sample FIFO with Threshold and Underrun Interrupts

This block buffers outgoing audio samples between a host register port and a serial audio shifter. Software writes 32-bit sample words into a data register. The shifter takes them back one at a time with a pop request, and each request is answered one cycle later with a valid strobe and a word. The queue holds 32 words.

Software can read the current fill level. It can program a threshold, and a request flag stays raised for as long as the level is at or below that threshold, which tells the host to refill. A pop that finds the queue empty returns a zero word and sets a sticky underrun flag; software removes the flag with a dedicated clear bit. A single interrupt line combines the two status flags through their enables. A flush command empties the queue and reads back as busy for a fixed number of cycles before it drops to zero by itself.

Register map (3-bit address): 0 = sample data (write only, reads 0), 1 = fill level, 2 = interrupt control, 3 = status, 4 = flush.

Top module: `tx_sample_fifo`

## Requirements
- R1: After reset the level reads 0, the control register reads 0, the flush register reads 0, the status register reads 1 (refill request set, since 0 <= threshold 0), and irq is low.
- R2: Words written to address 0 leave in write order. A pop_req in one cycle gives pop_valid high in the next cycle, with the word on pop_data.
- R3: Address 1 returns the fill level in bits 5:0, from 0 to 32. It rises by one for each accepted write and falls by one for each pop that returns data.
- R4: A data write while 32 words are stored is dropped. The level stays 32 and the stored words are read out unchanged.
- R5: Status bit 0 (refill request) is 1 exactly while the level is at or below the threshold, which is control bits 8:4. The flag is not sticky.
- R6: A pop while the level is 0 returns pop_valid high with pop_data = 0 and sets status bit 1 (underrun). A pop that returns data does not set it.
- R7: Status bit 1 stays set until a control write with bit 2 = 1. That write also loads bits 8:4, 1 and 0, and bit 2 itself always reads 0.
- R8: irq = (status bit 0 AND control bit 0) OR (status bit 1 AND control bit 1).
- R9: Writing 1 to bit 0 of address 4 empties the queue by the next cycle. Bit 0 of address 4 then reads 1 for 3 cycles and returns to 0 by itself. Data writes made while it reads 1 are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, taken from current state |
| pop_req | input | 1 | Shifter asks for the next sample |
| pop_valid | output | 1 | Response strobe, one cycle after pop_req |
| pop_data | output | 32 | Popped sample, or zero on underrun |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume the following about the inputs: at most one register write per cycle, pop_req is a plain one-cycle request with no handshake back, and the flush latency is at least one cycle. They also take the address to be one of the five decoded values whenever the write strobe matters. The bench drives every input on the falling clock edge and issues writes and pops through tasks that hold each strobe for exactly one cycle. It uses only the five defined addresses, so the stimulus stays inside these assumptions. Reads are combinational on the current state, so the bench samples them shortly after setting the address, with no write strobe active.

// File: rtl/tsf_pkg.sv
package tsf_pkg;

    typedef enum logic [2:0] {
        ADDR_DATA   = 3'd0,
        ADDR_LEVEL  = 3'd1,
        ADDR_CTRL   = 3'd2,
        ADDR_STATUS = 3'd3,
        ADDR_FLUSH  = 3'd4
    } tsf_addr_e;

    // control register bit positions
    localparam int CTRL_EN_REFILL = 0;
    localparam int CTRL_EN_UNDER  = 1;
    localparam int CTRL_CLR_UNDER = 2;
    localparam int CTRL_THR_LSB   = 4;

    // status register bit positions
    localparam int STAT_REFILL    = 0;
    localparam int STAT_UNDER     = 1;

    // flush register bit position
    localparam int FLUSH_BIT      = 0;

endpackage

// File: rtl/tsf_queue.sv
module tsf_queue #(
    parameter int DEPTH = 32,
    parameter int WIDTH = 32,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop_req,
    input  logic             flush,
    output logic [CW-1:0]    level,
    output logic             pop_valid,
    output logic [WIDTH-1:0] pop_data,
    output logic             pop_miss
);

    typedef struct packed {
        logic [AW-1:0]    wp;
        logic [AW-1:0]    rp;
        logic [CW-1:0]    cnt;
        logic             vld;
        logic [WIDTH-1:0] dout;
    } q_state_t;

    q_state_t st_d, st_q;
    logic [WIDTH-1:0] mem [DEPTH];
    logic full, empty, do_push, do_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        full    = (st_q.cnt == CW'(DEPTH));
        empty   = (st_q.cnt == '0);
        do_push = push && !full && !flush;
        do_pop  = pop_req && !empty;

        st_d      = st_q;
        st_d.vld  = pop_req;
        st_d.dout = do_pop ? mem[st_q.rp] : '0;

        if (flush) begin
            st_d.wp  = '0;
            st_d.rp  = '0;
            st_d.cnt = '0;
        end else begin
            if (do_push) st_d.wp = bump(st_q.wp);
            if (do_pop)  st_d.rp = bump(st_q.rp);
            case ({do_push, do_pop})
                2'b10:   st_d.cnt = st_q.cnt + 1'b1;
                2'b01:   st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[st_q.wp] <= push_data;
    end

    assign level     = st_q.cnt;
    assign pop_valid = st_q.vld;
    assign pop_data  = st_q.dout;
    assign pop_miss  = pop_req && empty;

endmodule

// File: rtl/tsf_regs.sv
module tsf_regs
    import tsf_pkg::*;
#(
    parameter int WIDTH        = 32,
    parameter int CW           = 6,
    parameter int THR_W        = 5,
    parameter int FLUSH_CYCLES = 3,
    localparam int FW = $clog2(FLUSH_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       addr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [CW-1:0]    level,
    input  logic             pop_miss,
    output logic             push,
    output logic             flush,
    output logic [WIDTH-1:0] rdata,
    output logic             irq,
    output logic             under_flag,
    output logic             flush_busy
);

    typedef struct packed {
        logic [THR_W-1:0] thr;
        logic             en_refill;
        logic             en_under;
        logic             under;
        logic [FW-1:0]    busy;
    } r_state_t;

    r_state_t st_d, st_q;
    logic wr_data, wr_ctrl, wr_flush, busy, refill_req;

    always_comb begin
        wr_data    = wr_en && (addr == ADDR_DATA);
        wr_ctrl    = wr_en && (addr == ADDR_CTRL);
        wr_flush   = wr_en && (addr == ADDR_FLUSH) && wdata[FLUSH_BIT];
        busy       = (st_q.busy != '0);
        refill_req = (level <= CW'(st_q.thr));

        st_d = st_q;
        if (wr_flush)  st_d.busy = FW'(FLUSH_CYCLES);
        else if (busy) st_d.busy = st_q.busy - 1'b1;

        if (wr_ctrl) begin
            st_d.thr       = wdata[CTRL_THR_LSB +: THR_W];
            st_d.en_refill = wdata[CTRL_EN_REFILL];
            st_d.en_under  = wdata[CTRL_EN_UNDER];
            if (wdata[CTRL_CLR_UNDER]) st_d.under = 1'b0;
        end
        if (pop_miss) st_d.under = 1'b1;

        rdata = '0;
        case (addr)
            ADDR_LEVEL: rdata[CW-1:0] = level;
            ADDR_CTRL: begin
                rdata[CTRL_THR_LSB +: THR_W] = st_q.thr;
                rdata[CTRL_EN_REFILL]        = st_q.en_refill;
                rdata[CTRL_EN_UNDER]         = st_q.en_under;
            end
            ADDR_STATUS: begin
                rdata[STAT_REFILL] = refill_req;
                rdata[STAT_UNDER]  = st_q.under;
            end
            ADDR_FLUSH: rdata[FLUSH_BIT] = busy;
            default:    rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign push       = wr_data && !busy;
    assign flush      = wr_flush;
    assign irq        = (refill_req && st_q.en_refill) || (st_q.under && st_q.en_under);
    assign under_flag = st_q.under;
    assign flush_busy = busy;

endmodule

// File: rtl/tx_sample_fifo.sv
module tx_sample_fifo #(
    parameter int DEPTH        = 32,
    parameter int WIDTH        = 32,
    parameter int THR_W        = 5,
    parameter int FLUSH_CYCLES = 3,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr_en,
    input  logic [2:0]       reg_addr,
    input  logic [WIDTH-1:0] reg_wdata,
    output logic [WIDTH-1:0] reg_rdata,
    input  logic             pop_req,
    output logic             pop_valid,
    output logic [WIDTH-1:0] pop_data,
    output logic             irq
);

    logic [CW-1:0] q_level;
    logic          q_push, q_flush, q_miss, r_under, r_busy;

    tsf_regs #(
        .WIDTH(WIDTH), .CW(CW), .THR_W(THR_W), .FLUSH_CYCLES(FLUSH_CYCLES)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_wr_en), .addr(reg_addr), .wdata(reg_wdata),
        .level(q_level), .pop_miss(q_miss),
        .push(q_push), .flush(q_flush), .rdata(reg_rdata), .irq(irq),
        .under_flag(r_under), .flush_busy(r_busy)
    );

    tsf_queue #(
        .DEPTH(DEPTH), .WIDTH(WIDTH)
    ) u_queue (
        .clk(clk), .rst_n(rst_n),
        .push(q_push), .push_data(reg_wdata),
        .pop_req(pop_req), .flush(q_flush),
        .level(q_level), .pop_valid(pop_valid), .pop_data(pop_data),
        .pop_miss(q_miss)
    );

endmodule

// File: rtl/tsf_chk.sv
module tsf_chk
    import tsf_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int WIDTH = 32,
    parameter int CW    = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr_en,
    input logic [2:0]       reg_addr,
    input logic [WIDTH-1:0] reg_wdata,
    input logic             pop_req,
    input logic             pop_valid,
    input logic [WIDTH-1:0] pop_data,
    input logic [CW-1:0]    level,
    input logic             under_flag,
    input logic             flush_busy
);

    // R2
    pop_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_req |=> pop_valid);

    // R3
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CW'(DEPTH));

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level == CW'(DEPTH)) && !pop_req && !(reg_wr_en && reg_addr == ADDR_FLUSH)
        |=> level == CW'(DEPTH));

    // R6
    underrun_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_req && (level == '0) |=> (pop_data == '0) && under_flag);

    // R7
    under_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        under_flag && !(reg_wr_en && reg_addr == ADDR_CTRL && reg_wdata[CTRL_CLR_UNDER])
        |=> under_flag);

    // R9
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en && (reg_addr == ADDR_FLUSH) && reg_wdata[FLUSH_BIT]
        |=> (level == '0) && flush_busy);

    // R9
    flush_no_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_busy |=> level <= $past(level));

endmodule

bind tx_sample_fifo tsf_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .pop_req(pop_req), .pop_valid(pop_valid), .pop_data(pop_data),
    .level(q_level), .under_flag(r_under), .flush_busy(r_busy)
);

// File: tb/sim_tx_sample_fifo.sv
module sim_tx_sample_fifo;

    localparam logic [2:0] A_DATA = 3'd0, A_LEVEL = 3'd1, A_CTRL = 3'd2,
                           A_STATUS = 3'd3, A_FLUSH = 3'd4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        pop_req = 1'b0;
    logic        pop_valid;
    logic [31:0] pop_data;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    tx_sample_fifo u0 (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .pop_req(pop_req), .pop_valid(pop_valid), .pop_data(pop_data),
        .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic pop(output logic v, output logic [31:0] d);
        pop_req = 1'b1;
        @(negedge clk);
        pop_req = 1'b0;
        v = pop_valid;
        d = pop_data;
    endtask

    task automatic flush_wait();
        wr(A_FLUSH, 32'h1);
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(A_LEVEL, v);  check("R1 level", v, 0);
        rd(A_CTRL, v);   check("R1 ctrl", v, 0);
        rd(A_FLUSH, v);  check("R1 flush", v, 0);
        rd(A_STATUS, v); check("R1 status", v, 1);
        check("R1 irq", {31'd0, irq}, 0);
    endtask

    task automatic t_order();
        logic [31:0] v, d;
        logic        ok;
        for (int i = 0; i < 5; i++) wr(A_DATA, 32'hC0DE_0000 + i);
        rd(A_LEVEL, v); check("R3 level after 5", v, 5);
        for (int i = 0; i < 5; i++) begin
            pop(ok, d);
            check("R2 valid", {31'd0, ok}, 1);
            check("R2 order", d, 32'hC0DE_0000 + i);
        end
        @(negedge clk);
        check("R2 valid drops", {31'd0, pop_valid}, 0);
        rd(A_LEVEL, v); check("R3 level drained", v, 0);
        rd(A_STATUS, v); check("R6 no underrun on data pops", v[1], 0);
    endtask

    task automatic t_full();
        logic [31:0] v, d;
        logic        ok;
        for (int i = 0; i < 33; i++) wr(A_DATA, 32'hA000_0000 + i);
        rd(A_LEVEL, v); check("R4 level at full", v, 32);
        for (int i = 0; i < 32; i++) begin
            pop(ok, d);
            check("R4 stored word", d, 32'hA000_0000 + i);
        end
        rd(A_LEVEL, v); check("R3 level empty", v, 0);
    endtask

    task automatic t_threshold();
        logic [31:0] v;
        wr(A_CTRL, (32'd16 << 4) | 32'h1);
        rd(A_CTRL, v); check("R7 ctrl readback", v, 32'h101);
        rd(A_STATUS, v); check("R5 request at 0", v[0], 1);
        check("R8 irq refill", {31'd0, irq}, 1);
        for (int i = 0; i < 16; i++) wr(A_DATA, i);
        rd(A_STATUS, v); check("R5 request at 16", v[0], 1);
        wr(A_DATA, 32'h77);
        rd(A_STATUS, v); check("R5 no request at 17", v[0], 0);
        check("R8 irq low", {31'd0, irq}, 0);
        wr(A_CTRL, (32'd31 << 4) | 32'h2);
        rd(A_STATUS, v); check("R5 request at 17 thr 31", v[0], 1);
        check("R8 refill masked", {31'd0, irq}, 0);
        flush_wait();
        wr(A_CTRL, 32'h0);
    endtask

    task automatic t_underrun();
        logic [31:0] v, d;
        logic        ok;
        pop(ok, d);
        check("R6 valid on empty", {31'd0, ok}, 1);
        check("R6 zero word", d, 0);
        rd(A_STATUS, v); check("R6 flag set", v[1], 1);
        repeat (5) @(negedge clk);
        rd(A_STATUS, v); check("R7 flag sticky", v[1], 1);
        check("R8 masked", {31'd0, irq}, 0);
        wr(A_CTRL, 32'h2);
        check("R8 irq underrun", {31'd0, irq}, 1);
        wr(A_CTRL, 32'h6);
        rd(A_STATUS, v); check("R7 flag cleared", v[1], 0);
        rd(A_CTRL, v);   check("R7 clear bit reads 0", v, 32'h2);
        check("R8 irq after clear", {31'd0, irq}, 0);
        wr(A_CTRL, 32'h0);
    endtask

    task automatic t_flush();
        logic [31:0] v, d;
        logic        ok;
        for (int i = 0; i < 10; i++) wr(A_DATA, 32'hF0 + i);
        wr(A_FLUSH, 32'h1);
        rd(A_FLUSH, v); check("R9 busy", v, 1);
        rd(A_LEVEL, v); check("R9 emptied", v, 0);
        wr(A_DATA, 32'hDEAD);
        rd(A_LEVEL, v); check("R9 write dropped", v, 0);
        rd(A_FLUSH, v); check("R9 busy 2", v, 1);
        @(negedge clk);
        rd(A_FLUSH, v); check("R9 busy 3", v, 1);
        @(negedge clk);
        rd(A_FLUSH, v); check("R9 self clear", v, 0);
        wr(A_DATA, 32'h5A5A);
        rd(A_LEVEL, v); check("R9 accepts after", v, 1);
        pop(ok, d);
        check("R9 word after flush", d, 32'h5A5A);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_order();
        t_full();
        t_threshold();
        t_underrun();
        t_flush();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule